// File: doc/BRIEF.md
# Deferred-Commit I2C Configuration Target

This block is a target-side I2C interface for a small bank of control registers. It samples the open-drain clock and data lines with a fast system clock and cleans them up. It finds start and stop conditions and answers to one fixed 7-bit device address. A write carries a register index and then any number of data bytes. A read returns register contents, starting at the current index.

Written bytes do not reach the register bank while the bus transfer is running. Each byte is held in a staging buffer together with its target index. Only after a stop condition does the block drain the buffer, oldest entry first, through a valid/ready commit stream into the register bank. The bank owns the ready signal and may hold it low to stall the drain. While ready is low, the head entry and valid stay put. An entry moves only on a cycle where valid and ready are both high. Reads use a plain combinational index/data port on the bank.

Top module: `i2c_cfg_target`

## Requirements
- R1: While the active-low reset is low, and right after it rises, the data-line drive (`sda_oe`) is released and `cmt_valid` is low. Bytes staged before the reset are discarded and are never committed.
- R2: The first byte after a start carries the device address 1001111 in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). On a match the block pulls data low through the ninth clock. On any other address it leaves the line released for the rest of that transfer.
- R3: A start is data falling while the clock is high. A stop is data rising while the clock is high. Data bits are taken on the clock's rising edge, and a data change while the clock is high never counts as a bit.
- R4: On a write, the byte after the address sets the register index from its low `$clog2(NUM_REGS)` bits. Each later data byte is acknowledged and staged with the current index. The index then advances by one, wrapping modulo NUM_REGS (15 is followed by 0 with 16 registers).
- R5: No commit entry appears before the stop that ends the write. After that stop, the staged entries come out in the order their bytes arrived.
- R6: Once `cmt_valid` is high it stays high, and `cmt_idx`/`cmt_data` stay unchanged, until a cycle with `cmt_ready` high.
- R7: A data byte that arrives when STAGE_DEPTH entries are already staged is not acknowledged, and the rest of the transfer up to the stop is ignored. The earlier entries are still committed.
- R8: On a read, each byte is shifted out MSB first from `rd_data` at the current index. The index advances after every byte, wrapping like R4, and a controller ACK starts the next byte.
- R9: After the controller answers a read byte with NACK, the block keeps the data line released until the next start.
- R10: A start that follows another start with no address bit clocked between them does not begin address matching: no acknowledge is given until the next stop.
- R11: While staged entries are still being committed, bus activity is ignored, so a transfer addressed to the block in that window gets no acknowledge.
- R12: A clock or data pulse shorter than FILT_LEN system clocks (3 by default) is filtered out and does not disturb the byte being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| rd_idx | output | $clog2(NUM_REGS) | Register index for the read port |
| rd_data | input | 8 | Register contents at `rd_idx`, combinational |
| cmt_valid | output | 1 | A staged entry is being offered to the bank |
| cmt_ready | input | 1 | Bank accepts the offered entry this cycle |
| cmt_idx | output | $clog2(NUM_REGS) | Register index of the offered entry |
| cmt_data | output | 8 | Data of the offered entry |

## Verification
A bus-line change reaches the control logic after two synchronizer flops, three filter samples and the output register. So an acknowledge or the next read bit shows on `sda_oe` about seven system clocks after the clock edge that triggers it. The bench therefore drives and samples at falling system-clock edges and reads the line in the middle of each bus clock-high phase, twenty-five clocks away from any edge. Commit entries appear about seven clocks after the stop. The bench looks at them only after a settle of thirty or more clocks, and during deliberate stalls it checks the held entry at two separate times.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_IDX,
    ST_IACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE,
    ST_COMMIT
  } tgt_state_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      // the output changes only after FILT_LEN agreeing samples
      if (&hist_q)       out_q <= 1'b1;
      else if (~|hist_q) out_q <= 1'b0;
    end
  end

  assign line_out = out_q;

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign start_det = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;

endmodule

// File: rtl/i2c_stage_buf.sv
module i2c_stage_buf #(
  parameter int DEPTH = 8,
  parameter int W     = 12,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign level = count;

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1001111,
  parameter int         NUM_REGS    = 16,
  parameter int         STAGE_DEPTH = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  localparam int        IDX_W       = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [7:0]       rd_data,
  output logic             cmt_valid,
  input  logic             cmt_ready,
  output logic [IDX_W-1:0] cmt_idx,
  output logic [7:0]       cmt_data
);

  localparam int ENT_W = IDX_W + 8;
  localparam int LVL_W = $clog2(STAGE_DEPTH + 1);

  // line conditioning, one filter per bus line
  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {scl_in, sda_in};

  generate
    for (genvar gi = 0; gi < 2; gi++) begin : g_line
      i2c_line_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
      ) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (raw_lines[gi]),
        .line_out(filt_lines[gi])
      );
    end
  endgenerate

  logic scl_f, sda_f;
  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_bus_events u_ev (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  tgt_state_t       state;
  logic [7:0]       sh;
  logic [7:0]       tx;
  logic [3:0]       cnt;
  logic [IDX_W-1:0] ptr;
  logic             rw;
  logic             oe_q;
  logic             start_pend;
  logic             mack;

  logic             push_req, pop_req;
  logic             stg_full, stg_empty;
  logic [LVL_W-1:0] stg_level;
  logic [ENT_W-1:0] stg_dout;
  logic             byte_done, bus_live;

  assign byte_done = scl_fall && (cnt == 4'd8);
  assign bus_live  = (state != ST_COMMIT) && !start_det && !stop_det;
  assign push_req  = bus_live && (state == ST_WDATA) && byte_done && !stg_full;
  assign cmt_valid = (state == ST_COMMIT) && !stg_empty;
  assign pop_req   = cmt_valid && cmt_ready;

  i2c_stage_buf #(
    .DEPTH(STAGE_DEPTH),
    .W    (ENT_W)
  ) u_stage (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push_req),
    .din  ({ptr, sh}),
    .pop  (pop_req),
    .dout (stg_dout),
    .full (stg_full),
    .empty(stg_empty),
    .level(stg_level)
  );

  assign cmt_idx  = stg_dout[ENT_W-1:8];
  assign cmt_data = stg_dout[7:0];
  assign sda_oe   = oe_q;
  assign rd_idx   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sh         <= '0;
      tx         <= '0;
      cnt        <= '0;
      ptr        <= '0;
      rw         <= 1'b0;
      oe_q       <= 1'b0;
      start_pend <= 1'b0;
      mack       <= 1'b0;
    end else begin
      // a clocked address bit or a stop ends the "just started" window
      if ((scl_fall && cnt != 4'd0) || stop_det) start_pend <= 1'b0;

      if (state == ST_COMMIT) begin
        if (stg_empty) state <= ST_IDLE;
      end else if (stop_det) begin
        oe_q  <= 1'b0;
        state <= stg_empty ? ST_IDLE : ST_COMMIT;
      end else if (start_det) begin
        oe_q <= 1'b0;
        cnt  <= '0;
        if (start_pend) begin
          state <= ST_IGNORE;
        end else begin
          state      <= ST_ADDR;
          start_pend <= 1'b1;
        end
      end else begin
        case (state)
          ST_ADDR, ST_IDX, ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (byte_done) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw    <= sh[0];
                  oe_q  <= 1'b1;
                  state <= ST_AACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (state == ST_IDX) begin
                ptr   <= sh[IDX_W-1:0];
                oe_q  <= 1'b1;
                state <= ST_IACK;
              end else if (!stg_full) begin
                ptr   <= ptr + IDX_W'(1);
                oe_q  <= 1'b1;
                state <= ST_WACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx    <= rd_data;
                oe_q  <= ~rd_data[7];
                state <= ST_RDATA;
              end else begin
                oe_q  <= 1'b0;
                state <= ST_IDX;
              end
            end
          end
          ST_IACK, ST_WACK: begin
            if (scl_fall) begin
              oe_q  <= 1'b0;
              state <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                oe_q  <= 1'b0;
                ptr   <= ptr + IDX_W'(1);
                state <= ST_RACK;
              end else begin
                tx   <= {tx[6:0], 1'b0};
                oe_q <= ~tx[6];
                cnt  <= cnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_f;
            end else if (scl_fall) begin
              if (mack) begin
                tx    <= rd_data;
                oe_q  <= ~rd_data[7];
                cnt   <= '0;
                state <= ST_RDATA;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_cfg_target_chk.sv
module i2c_cfg_target_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 4,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             cmt_valid,
  input logic             cmt_ready,
  input logic [IDX_W-1:0] cmt_idx,
  input logic [7:0]       cmt_data,
  input logic             stop_det,
  input logic             start_det,
  input logic             start_pend,
  input logic             in_commit,
  input logic             in_idle,
  input logic             in_ignore,
  input logic [LVL_W-1:0] stg_level
);

  AST_CMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && !cmt_ready |=> cmt_valid && $stable(cmt_idx) && $stable(cmt_data)); // R6

  AST_CMT_ONLY_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> in_commit); // R5

  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_commit) |-> $past(stop_det)); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe); // R1

  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stg_level <= LVL_W'(DEPTH)); // R7

  AST_DOUBLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_det && start_pend && !in_commit |=> in_ignore); // R10

  AST_COMMIT_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    in_commit && !cmt_valid |=> in_idle); // R11

endmodule

bind i2c_cfg_target i2c_cfg_target_chk #(
  .DEPTH(STAGE_DEPTH),
  .IDX_W(IDX_W),
  .LVL_W(LVL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe    (sda_oe),
  .cmt_valid (cmt_valid),
  .cmt_ready (cmt_ready),
  .cmt_idx   (cmt_idx),
  .cmt_data  (cmt_data),
  .stop_det  (stop_det),
  .start_det (start_det),
  .start_pend(start_pend),
  .in_commit (state == i2c_cfg_pkg::ST_COMMIT),
  .in_idle   (state == i2c_cfg_pkg::ST_IDLE),
  .in_ignore (state == i2c_cfg_pkg::ST_IGNORE),
  .stg_level (stg_level)
);

// File: tb/i2c_cfg_target_bench.sv
module i2c_cfg_target_bench;

  localparam int NUM_REGS    = 16;
  localparam int STAGE_DEPTH = 8;
  localparam int Q           = 25;
  localparam logic [7:0] ADDR_W = {7'b1001111, 1'b0};
  localparam logic [7:0] ADDR_R = {7'b1001111, 1'b1};

  // each vector: register index, first data byte, second data byte
  localparam logic [23:0] VECS [4] = '{
    {8'h01, 8'h3C, 8'hC3},
    {8'h06, 8'hFF, 8'h00},
    {8'h0B, 8'h81, 8'h7E},
    {8'h0F, 8'hA5, 8'h5A}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic cmt_ready = 1'b1;
  wire  sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  wire  [3:0] rd_idx;
  wire  [7:0] rd_data;
  wire  cmt_valid;
  wire  [3:0] cmt_idx;
  wire  [7:0] cmt_data;

  logic [7:0] bank [NUM_REGS] = '{default: 8'h00};
  logic [3:0] log_idx [64];
  logic [7:0] log_dat [64];
  int log_n = 0;

  assign rd_data = bank[rd_idx];

  always @(posedge clk) begin
    if (cmt_valid && cmt_ready) begin
      bank[cmt_idx]         <= cmt_data;
      log_idx[log_n[5:0]]   <= cmt_idx;
      log_dat[log_n[5:0]]   <= cmt_data;
      log_n                 <= log_n + 1;
    end
  end

  i2c_cfg_target u_i2c_cfg_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_m),
    .sda_in   (sda_line),
    .sda_oe   (sda_oe),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .cmt_valid(cmt_valid),
    .cmt_ready(cmt_ready),
    .cmt_idx  (cmt_idx),
    .cmt_data (cmt_data)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic write_byte(input logic [7:0] b, input bit glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0;
      if (glitch) begin
        tick(Q / 2); scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(Q / 2);
      end else begin
        tick(Q);
      end
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_line}; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int base;

    // R1 reset state
    tick(5);
    chk("R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(3);
    chk("R1 oe after reset", sda_oe, 0);
    chk("R1 valid after reset", cmt_valid, 0);

    // table walk: write two bytes, then read them back
    for (int v = 0; v < 4; v++) begin
      logic [3:0] ix;
      logic [7:0] d0, d1;
      ix = VECS[v][19:16];
      d0 = VECS[v][15:8];
      d1 = VECS[v][7:0];
      base = log_n;
      bus_start();
      write_byte(ADDR_W, 1'b0, ack); chk("R2 R3 address ack", ack, 0);
      write_byte({4'h0, ix}, 1'b0, ack); chk("R4 index ack", ack, 0);
      write_byte(d0, 1'b0, ack); chk("R4 data0 ack", ack, 0);
      write_byte(d1, 1'b0, ack); chk("R4 data1 ack", ack, 0);
      bus_stop();
      tick(30);
      chk("R5 commit count", log_n - base, 2);
      chk("R5 first idx", log_idx[base], ix);
      chk("R5 first data", log_dat[base], d0);
      chk("R4 second idx wraps", log_idx[base + 1], 4'(ix + 4'd1));
      chk("R5 second data", log_dat[base + 1], d1);
      bus_start();
      write_byte(ADDR_W, 1'b0, ack);
      write_byte({4'h0, ix}, 1'b0, ack);
      bus_start();
      write_byte(ADDR_R, 1'b0, ack); chk("R2 read address ack", ack, 0);
      read_byte(1'b1, rb); chk("R8 read byte0", rb, d0);
      read_byte(1'b0, rb); chk("R8 read byte1", rb, d1);
      bus_stop();
      tick(10);
    end

    // R2 mismatched address gets no ack
    base = log_n;
    bus_start();
    write_byte({7'b1001110, 1'b0}, 1'b0, ack); chk("R2 wrong address nack", ack, 1);
    write_byte(8'h05, 1'b0, ack); chk("R2 released after mismatch", ack, 1);
    bus_stop();
    tick(30);
    chk("R2 no commit after mismatch", log_n, base);

    // R5 R6 R11 deferral and back-pressure
    cmt_ready = 1'b0;
    base = log_n;
    bus_start();
    write_byte(ADDR_W, 1'b0, ack);
    write_byte(8'h03, 1'b0, ack);
    write_byte(8'h11, 1'b0, ack);
    write_byte(8'h22, 1'b0, ack);
    chk("R5 no valid before stop", cmt_valid, 0);
    bus_stop();
    tick(40);
    chk("R6 valid under stall", cmt_valid, 1);
    chk("R6 held idx", cmt_idx, 3);
    tick(17);
    chk("R6 still valid", cmt_valid, 1);
    chk("R6 held data", cmt_data, 8'h11);
    bus_start();
    write_byte(ADDR_W, 1'b0, ack); chk("R11 no ack while committing", ack, 1);
    bus_stop();
    chk("R6 nothing moved", log_n, base);
    cmt_ready = 1'b1;
    tick(20);
    chk("R5 drained count", log_n - base, 2);
    chk("R5 order data0", log_dat[base], 8'h11);
    chk("R5 order data1", log_dat[base + 1], 8'h22);

    // R7 staging full
    base = log_n;
    bus_start();
    write_byte(ADDR_W, 1'b0, ack);
    write_byte(8'h00, 1'b0, ack);
    for (int i = 0; i < STAGE_DEPTH + 1; i++) begin
      write_byte(8'(i * 3 + 1), 1'b0, ack);
      chk("R7 ack per byte", ack, (i < STAGE_DEPTH) ? 0 : 1);
    end
    bus_stop();
    tick(40);
    chk("R7 committed count", log_n - base, STAGE_DEPTH);
    chk("R7 last idx", log_idx[base + STAGE_DEPTH - 1], STAGE_DEPTH - 1);

    // R9 controller NACK releases the line
    bus_start();
    write_byte(ADDR_W, 1'b0, ack);
    write_byte(8'h02, 1'b0, ack);
    bus_start();
    write_byte(ADDR_R, 1'b0, ack);
    read_byte(1'b0, rb); chk("R8 read reg2", rb, 8'h07);
    read_byte(1'b0, rb); chk("R9 released after nack", rb, 8'hFF);
    bus_stop();
    tick(10);

    // R10 back-to-back start
    base = log_n;
    bus_start();
    bus_start();
    write_byte(ADDR_W, 1'b0, ack); chk("R10 no ack after double start", ack, 1);
    write_byte(8'h05, 1'b0, ack); chk("R10 still ignored", ack, 1);
    bus_stop();
    tick(30);
    chk("R10 no commit", log_n, base);
    bus_start();
    write_byte(ADDR_W, 1'b0, ack); chk("R10 recovers after stop", ack, 0);
    bus_stop();
    tick(10);

    // R12 short clock glitches are filtered
    base = log_n;
    bus_start();
    write_byte(ADDR_W, 1'b1, ack); chk("R12 address with glitches", ack, 0);
    write_byte(8'h0A, 1'b1, ack);
    write_byte(8'h6B, 1'b1, ack);
    bus_stop();
    tick(30);
    chk("R12 committed idx", log_idx[base], 8'h0A);
    chk("R12 committed data", log_dat[base], 8'h6B);

    // R1 reset discards staged bytes
    base = log_n;
    bus_start();
    write_byte(ADDR_W, 1'b0, ack);
    write_byte(8'h09, 1'b0, ack);
    write_byte(8'h77, 1'b0, ack);
    rst_n = 1'b0;
    tick(3);
    chk("R1 oe during mid reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(10);
    bus_stop();
    tick(30);
    chk("R1 staged bytes dropped", log_n, base);
    chk("R1 valid stays low", cmt_valid, 0);

    finish_run();
  end

endmodule